// File: doc/BRIEF.md
# Scrambled Code-Store Programming and Verify Port

This block is the parallel programming and read-back port of an on-chip code store. A six-pin mode group (`cfg`) together with a flag that says the programming supply is raised selects one operation. The operations are: write a code byte, write a byte of the 64-entry scramble key, clear one of three lock bits, read back code for verification, or read the fixed identification bytes. Every write happens once per rising edge of the program strobe. A write can only clear bits: the cell becomes the old value ANDed with the data.

Code read-back is never plain. Each code byte is XNORed with the key byte chosen by the low six address bits. A blank key (all FFh) therefore returns the code unchanged. The key itself has no read path. The security block supplies two permission flags, one for programming and one for verification, and it observes the lock bits on `lock_n`. A synchronous erase, or reset, returns the code, the key and the lock bits to all ones. The code depth is set by `AW`; a full 8 KB store uses `AW = 13`.

Top module: `prog_verify_port`

## Requirements
- R1: `cfg` is {psel, m4, oe_n, m2, m1, m0}, with bit 5 first. The encodings are:
  - 6'h0F: write code
  - 6'h0D: write key
  - 6'h07: verify code
  - 6'h00: identification read
  - 6'h1F: clear lock bit 0
  - 6'h1C: clear lock bit 1
  - 6'h16: clear lock bit 2
  
  Any other value is idle.
- R2: In write-code mode, with `vpp_hi` and `prog_ok` high, a strobe rising edge (strobe sampled 1 after being sampled 0) sets `code[addr]` to `code[addr] & din`. A strobe that is held high writes only once.
- R3: In verify mode with `verify_ok` high, `dout` is `~(code[addr] ^ key[addr[5:0]])` and `dout_en` is 1.
- R4: In write-key mode, with `vpp_hi` and `prog_ok` high, a strobe rising edge sets `key[addr[5:0]]` to `key[addr[5:0]] & din`. No mode outputs a key byte directly.
- R5: In identification mode, `dout_en` is 1 and `dout` returns these values by address:
  - 30h: 58h
  - 31h: 57h
  - 60h: `PART_ID` (default ADh)
  - 61h: FFh
  - any other address: FFh
- R6: A strobe rising edge in a lock mode with `vpp_hi` high clears `lock_n` bit 0, 1 or 2. This does not depend on `prog_ok`. A lock bit never returns to 1 except by erase or reset.
- R7: `dout_en` is 1 only in verify mode with `verify_ok` high, or in identification mode. Otherwise `dout_en` is 0 and `dout` is FFh.
- R8: A strobe rising edge without `vpp_hi` changes nothing. A code or key write while `prog_ok` is low changes nothing.
- R9: Reset or `erase` sets every code byte, every key byte and `lock_n` to all ones. Erase takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| erase | input | 1 | fill all arrays and lock bits with ones |
| cfg | input | 6 | mode pin group, see R1 |
| vpp_hi | input | 1 | programming supply present |
| strobe | input | 1 | program pulse, acts on rising edge |
| prog_ok | input | 1 | security allows code/key writes |
| verify_ok | input | 1 | security allows code verify |
| addr | input | AW | byte address |
| din | input | 8 | write data |
| dout | output | 8 | read data, FFh when not driven |
| dout_en | output | 1 | drive enable for read data |
| lock_n | output | 3 | lock bits, 0 = programmed |

## Verification
The bench leaves code at FFh behind a programmed key byte. A design that failed to scramble would then return FFh instead of the key value. It also repeats the key index at two addresses 40h apart; a design that picked the key with the wrong address bits would decode only one of them. The strobe is held high while the data changes; a level-triggered write would AND in the second value. The bench also attempts writes without the supply flag, without permission and with `oe_n` high; a leaky design would change stored bytes or drive the bus.

// File: rtl/prog_verify_port.sv
module prog_verify_port #(
  parameter int AW      = 11,
  parameter int KW      = 6,
  parameter logic [7:0] PART_ID = 8'hAD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic [5:0]    cfg,
  input  logic          vpp_hi,
  input  logic          strobe,
  input  logic          prog_ok,
  input  logic          verify_ok,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic [2:0]    lock_n
);
  localparam int DEPTH  = 1 << AW;
  localparam int KDEPTH = 1 << KW;
  localparam logic [5:0] M_WCODE = 6'h0F, M_WKEY = 6'h0D, M_VER = 6'h07,
                         M_SIG = 6'h00, M_LK0 = 6'h1F, M_LK1 = 6'h1C, M_LK2 = 6'h16;

  logic [7:0] code_q [DEPTH];
  logic [7:0] key_q  [KDEPTH];
  logic       strobe_q;

  wire pulse  = strobe & ~strobe_q & vpp_hi;
  wire wr_ok  = pulse & prog_ok;
  wire [KW-1:0] kidx = addr[KW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || erase) begin
      for (int i = 0; i < DEPTH; i++)  code_q[i] <= 8'hFF;
      for (int j = 0; j < KDEPTH; j++) key_q[j]  <= 8'hFF;
      lock_n <= 3'b111;
    end else if (pulse) begin
      case (cfg)
        M_WCODE: if (wr_ok) code_q[addr] <= code_q[addr] & din;
        M_WKEY:  if (wr_ok) key_q[kidx]  <= key_q[kidx] & din;
        M_LK0:   lock_n[0] <= 1'b0;
        M_LK1:   lock_n[1] <= 1'b0;
        M_LK2:   lock_n[2] <= 1'b0;
        default: ;
      endcase
    end
  end

  logic [7:0] sig_byte;
  always_comb begin
    sig_byte = 8'hFF;
    if (addr == AW'('h30)) sig_byte = 8'h58;
    if (addr == AW'('h31)) sig_byte = 8'h57;
    if (addr == AW'('h60)) sig_byte = PART_ID;
  end

  wire rd_ver = (cfg == M_VER) & verify_ok;
  wire rd_sig = (cfg == M_SIG);

  assign dout_en = rd_ver | rd_sig;
  assign dout    = rd_ver ? ~(code_q[addr] ^ key_q[kidx]) :
                   rd_sig ? sig_byte : 8'hFF;

  p_sig_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 6'h00 && addr == AW'('h30)) |-> (dout_en && dout == 8'h58));

  p_lock_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !erase |=> ((lock_n & ~$past(lock_n)) == 3'b000));

  p_erase_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (lock_n == 3'b111));

  p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe) && !erase) |=> $stable(lock_n));

  p_verify_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == 6'h07 && !verify_ok) |-> (!dout_en && dout == 8'hFF));
endmodule

// File: tb/sim_prog_verify_port.sv
`timescale 1ns/100ps
module sim_prog_verify_port;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, erase = 0, vpp_hi = 0, strobe = 0, prog_ok = 1, verify_ok = 1;
  logic [5:0] cfg = 6'h3F;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = 8'hFF;
  logic [7:0] dout;
  logic dout_en;
  logic [2:0] lock_n;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  prog_verify_port #(.AW(AW)) u0 (.clk, .rst_n, .erase, .cfg, .vpp_hi, .strobe,
    .prog_ok, .verify_ok, .addr, .din, .dout, .dout_en, .lock_n);

  // behavioural reference
  byte unsigned m_code [DEPTH];
  byte unsigned m_key [64];
  bit [2:0] m_lock;
  bit m_prev;

  always @(posedge clk) begin
    bit edge_now;
    edge_now = strobe && !m_prev && vpp_hi;
    if (!rst_n || erase) begin
      foreach (m_code[i]) m_code[i] = 8'hFF;
      foreach (m_key[i])  m_key[i]  = 8'hFF;
      m_lock = 3'b111;
    end else if (edge_now) begin
      if (cfg == 6'h0F && prog_ok) m_code[addr] = m_code[addr] & din;
      else if (cfg == 6'h0D && prog_ok) m_key[addr % 64] = m_key[addr % 64] & din;
      else if (cfg == 6'h1F) m_lock[0] = 0;
      else if (cfg == 6'h1C) m_lock[1] = 0;
      else if (cfg == 6'h16) m_lock[2] = 0;
    end
    m_prev = rst_n ? strobe : 1'b0;
  end

  function automatic logic [8:0] model_out();
    if (cfg == 6'h07 && verify_ok)
      return {1'b1, 8'(~(m_code[addr] ^ m_key[addr % 64]))};
    if (cfg == 6'h00) begin
      case (int'(addr))
        'h30: return {1'b1, 8'h58};
        'h31: return {1'b1, 8'h57};
        'h60: return {1'b1, 8'hAD};
        default: return {1'b1, 8'hFF};
      endcase
    end
    return {1'b0, 8'hFF};
  endfunction

  always @(negedge clk) if (rst_n) begin
    n_chk++;
    if ({dout_en, dout} !== model_out() || lock_n !== m_lock) begin
      n_fail++;
      $display("FAIL R7 per-cycle: act en=%b d=%h lock=%b exp en=%b d=%h lock=%b",
               dout_en, dout, lock_n, model_out() >> 8, model_out() & 8'hFF, m_lock);
    end
  end

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(logic [5:0] c, int a, logic [7:0] d);
    cfg = c; addr = AW'(a); din = d; vpp_hi = 1; step();
    strobe = 1; step(); strobe = 0; step(); vpp_hi = 0;
  endtask

  task automatic rd(logic [5:0] c, int a, string tag, logic [8:0] exp);
    cfg = c; addr = AW'(a); @(negedge clk);
    chk(tag, {dout_en, dout}, exp); step();
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: act hung exp done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    chk("R9 reset lock", {6'd0, lock_n}, 9'h007);
    rd(6'h07, 'h005, "R9 reset code blank", 9'h1FF);

    wr(6'h0F, 'h005, 8'h3C);
    wr(6'h0F, 'h045, 8'hA5);
    rd(6'h07, 'h005, "R3 blank key passes code", 9'h13C);
    rd(6'h07, 'h045, "R3 blank key passes code", 9'h1A5);
    wr(6'h0F, 'h005, 8'hF0);
    rd(6'h07, 'h005, "R2 write ANDs old", 9'h130);

    wr(6'h0D, 'h005, 8'h0F);
    rd(6'h07, 'h005, "R3 scramble", 9'h1C0);
    rd(6'h07, 'h045, "R3 key index low bits", 9'h155);
    rd(6'h07, 'h085, "R4 blank code shows key", 9'h10F);
    rd(6'h07, 'h006, "R3 other key byte blank", 9'h1FF);
    rd(6'h0D, 'h005, "R4 key not readable", 9'h0FF);

    rd(6'h0F, 'h005, "R7 oe_n high no drive", 9'h0FF);
    verify_ok = 0;
    rd(6'h07, 'h005, "R7 verify disabled", 9'h0FF);
    verify_ok = 1;

    prog_ok = 0; wr(6'h0F, 'h006, 8'h00); prog_ok = 1;
    rd(6'h07, 'h006, "R8 no permission", 9'h1FF);
    cfg = 6'h0F; addr = AW'('h006); din = 8'h00; step(); strobe = 1; step(); strobe = 0; step();
    rd(6'h07, 'h006, "R8 no supply", 9'h1FF);

    cfg = 6'h0F; addr = AW'('h007); din = 8'hF0; vpp_hi = 1; step();
    strobe = 1; step(); din = 8'h0F; step(); step(); strobe = 0; step(); vpp_hi = 0;
    rd(6'h07, 'h007, "R2 held strobe one write", 9'h1F0);

    rd(6'h00, 'h030, "R5 id 30h", 9'h158);
    rd(6'h00, 'h031, "R5 id 31h", 9'h157);
    rd(6'h00, 'h060, "R5 id 60h", 9'h1AD);
    rd(6'h00, 'h061, "R5 id 61h", 9'h1FF);
    rd(6'h00, 'h062, "R5 id other", 9'h1FF);
    rd(6'h2A, 'h005, "R1 idle code", 9'h0FF);

    prog_ok = 0; wr(6'h1C, 0, 8'h00); prog_ok = 1;
    chk("R6 lock1", {6'd0, lock_n}, 9'h005);
    wr(6'h16, 0, 8'h00);
    chk("R6 lock2", {6'd0, lock_n}, 9'h001);
    wr(6'h1F, 0, 8'h00);
    chk("R6 lock0", {6'd0, lock_n}, 9'h000);

    cfg = 6'h0F; addr = AW'('h010); din = 8'h00; vpp_hi = 1; step();
    strobe = 1; erase = 1; step(); strobe = 0; erase = 0; vpp_hi = 0; step();
    chk("R9 erase lock", {6'd0, lock_n}, 9'h007);
    rd(6'h07, 'h005, "R9 erase code+key", 9'h1FF);
    rd(6'h07, 'h010, "R9 erase beats write", 9'h1FF);
    rd(6'h07, 'h085, "R9 erase key", 9'h1FF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule